// File: doc/BRIEF.md
# Auto-Reload Timer with Selectable Clock Source

This block is an 8-bit up-counter that reloads itself when it overflows. Each count step comes from a chain of two stages. The first stage is a source multiplexer. It picks the system clock, the system clock divided by three, or selected edges of an external pin. The pin is synchronised through a two-flop chain before its edges are detected. The second stage is a free-running power-of-two prescaler.

When the counter steps past its maximum, it takes the value in the reload register and raises a one-cycle overflow strobe. When a step lands the counter on the value of the compare register, a one-cycle match strobe is raised.

Software reaches four byte-wide registers through a plain write-enable bus with a combinational read port:
- address 0: control
- address 1: reload
- address 2: compare
- address 3: the live counter, which can be read and overwritten while it runs

The bus has no handshake: a write takes effect on the clock edge where `bus_we` is high, and a read is valid in the same cycle the address is presented.

Top module: `reload_timer`

## Requirements
- R1: Control bits [7:5] hold a code k from 0 to 7. The prescaler passes one count step for every 2^k source ticks, so a 128-cycle window on the system clock source advances the counter by 128>>k.
- R2: Writing new select bits does not clear the prescaler's internal count. Alternating the code between 7 and 6 every 40 cycles on the system clock still lets count steps through.
- R3: Control bit 4 always reads back as 0, whatever value is written to it.
- R4: Control bits [1:0] pick the source: 00 = system clock, 01 = system clock divided by 3 (43 ticks in any 129 cycles), 10 = external pin edges, 11 = stopped. While the code is 11, the counter holds its value.
- R5: Control bit 2 enables pin edges; when it is 0, the pin has no effect. Control bit 3 selects the edge: 0 = rising, 1 = falling. The pin passes through two synchroniser flops, so an edge placed mid-cycle changes the counter on the third rising clock edge after it. Each selected edge gives exactly one source tick.
- R6: A count step taken at 8'hFF loads the reload register (address 1) instead of wrapping to 0. `ovf_pulse` is high for exactly the one cycle in which the reloaded value is first visible.
- R7: A count step that puts the counter on the compare register's value (address 2) raises `cmp_pulse` for exactly the following cycle.
- R8: A write to address 3 replaces the counter on that clock edge and takes priority over a step in the same cycle. Reading address 3 returns the live counter.
- R9: Reset clears control, reload, compare and both strobes. Reset does not clear the counter, and the counter does not step while reset is held.
- R10: Address map: 0 = control, 1 = reload, 2 = compare, 3 = counter. Each reads back what was last written, apart from bit 4 of control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tmr_pin | input | 1 | External timer input, asynchronous |
| ovf_pulse | output | 1 | One-cycle overflow/reload strobe |
| cmp_pulse | output | 1 | One-cycle compare-match strobe |

## Verification
Some properties are checked on every cycle:
- an overflow strobe always follows a count step taken at 8'hFF;
- the counter holds the reload value whenever the overflow strobe is high;
- a match strobe always coincides with the counter equalling the compare value;
- the reserved control bit is always zero;
- the stopped source never lets the counter move.

Other behaviour needs the bench's own scenarios:
- the exact step rates for each prescale code and for the divide-by-3 path;
- the prescaler surviving changes to its select bits;
- the synchroniser latency, edge polarity and edge-enable gating on the pin;
- the counter keeping its value through reset.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'b00,
    SRC_DIV3 = 2'b01,
    SRC_PIN  = 2'b10,
    SRC_OFF  = 2'b11
  } src_e;

  typedef struct packed {
    logic [2:0] psel;
    logic       rsvd;
    logic       fall;
    logic       edge_en;
    src_e       src;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RLD  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_CNT  = 2'd3;

endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src
  import rtimer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV         = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic edge_en,
  input  logic fall,
  input  logic pin,
  output logic tick
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [DW-1:0]          div_q;
  logic                   pin_s, rise_hit, fall_hit, edge_hit, div_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
      div_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      last_q <= sync_q[SYNC_STAGES-1];
      div_q  <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign rise_hit = pin_s & ~last_q;
  assign fall_hit = ~pin_s & last_q;
  assign edge_hit = edge_en & (fall ? fall_hit : rise_hit);
  assign div_hit  = (div_q == DIV_LAST);

  always_comb begin
    unique case (src)
      SRC_SYS:  tick = 1'b1;
      SRC_DIV3: tick = div_hit;
      SRC_PIN:  tick = edge_hit;
      default:  tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_out
);
  localparam int unsigned CW = (1 << SEL_W) - 1;

  logic [CW-1:0] pre_q;
  logic [CW-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (tick_in) pre_q <= pre_q + 1'b1;
  end

  always_comb mask = ~({CW{1'b1}} << sel);

  assign tick_out = tick_in && ((pre_q & mask) == mask);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         ld_we,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt,
  output logic         ovf,
  output logic         hit
);
  logic [W-1:0] cnt_q, nxt;
  logic         at_top, adv;

  assign at_top = (cnt_q == {W{1'b1}});
  assign nxt    = at_top ? reload : cnt_q + 1'b1;
  assign adv    = rst_n && step && !ld_we;

  always_ff @(posedge clk) begin
    if (ld_we)    cnt_q <= ld_val;
    else if (adv) cnt_q <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      hit <= 1'b0;
    end else begin
      ovf <= adv && at_top;
      hit <= adv && (nxt == cmp_val);
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtimer_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         tmr_pin,
  output logic         ovf_pulse,
  output logic         cmp_pulse
);
  localparam int unsigned SEL_W = 3;

  ctrl_t        ctrl_q;
  logic [W-1:0] rld_q, cmp_q, cnt_w;
  logic         ld_we, src_tick, step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rld_q  <= '0;
      cmp_q  <= '0;
    end else if (bus_we) begin
      unique case (bus_addr)
        A_CTRL: begin
          ctrl_q      <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
          ctrl_q.rsvd <= 1'b0;
        end
        A_RLD:   rld_q <= bus_wdata;
        A_CMP:   cmp_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign ld_we = rst_n && bus_we && (bus_addr == A_CNT);

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = W'(ctrl_q);
      A_RLD:   bus_rdata = rld_q;
      A_CMP:   bus_rdata = cmp_q;
      default: bus_rdata = cnt_w;
    endcase
  end

  tmr_tick_src #(.SYNC_STAGES(SYNC_STAGES), .DIV(3)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (ctrl_q.src),
    .edge_en (ctrl_q.edge_en),
    .fall    (ctrl_q.fall),
    .pin     (tmr_pin),
    .tick    (src_tick)
  );

  tmr_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (src_tick),
    .sel      (ctrl_q.psel),
    .tick_out (step)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .ld_we   (ld_we),
    .ld_val  (bus_wdata),
    .reload  (rld_q),
    .cmp_val (cmp_q),
    .cnt     (cnt_w),
    .ovf     (ovf_pulse),
    .hit     (cmp_pulse)
  );

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic [W-1:0] reload,
  input logic [W-1:0] cmp_val,
  input logic [7:0]   ctrl,
  input logic         ld_we,
  input logic         ovf,
  input logic         hit
);

  p_ovf_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (cnt == $past(reload)));

  p_ovf_from_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> ($past(cnt) == {W{1'b1}}));

  p_hit_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (cnt == $past(cmp_val)));

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[4] == 1'b0);

  p_stopped_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1:0] == 2'b11 && !ld_we) |=> $stable(cnt));

endmodule

bind reload_timer reload_timer_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt     (cnt_w),
  .reload  (rld_q),
  .cmp_val (cmp_q),
  .ctrl    (8'(ctrl_q)),
  .ld_we   (ld_we),
  .ovf     (ovf_pulse),
  .hit     (cmp_pulse)
);

// File: tb/reload_timer_test.sv
module reload_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tmr_pin = 1'b0;
  logic       ovf_pulse, cmp_pulse;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  reload_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tmr_pin   (tmr_pin),
    .ovf_pulse (ovf_pulse),
    .cmp_pulse (cmp_pulse)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] win;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'd128, 16'd128},
    '{8'h20, 16'd128, 16'd64},
    '{8'h40, 16'd128, 16'd32},
    '{8'h60, 16'd128, 16'd16},
    '{8'h80, 16'd128, 16'd8},
    '{8'hA0, 16'd128, 16'd4},
    '{8'hC0, 16'd128, 16'd2},
    '{8'hE0, 16'd128, 16'd1},
    '{8'h01, 16'd129, 16'd43},
    '{8'h21, 16'd132, 16'd22},
    '{8'h03, 16'd128, 16'd0},
    '{8'h06, 16'd128, 16'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a, b;

    // R9, R10: reset state
    repeat (3) @(negedge clk);
    check("R9 ovf in reset", int'(ovf_pulse), 0);
    check("R9 cmp in reset", int'(cmp_pulse), 0);
    rst_n = 1'b1;
    rd(2'd0, a); check("R9 ctrl after reset", a, 0);
    rd(2'd1, a); check("R9 reload after reset", a, 0);
    rd(2'd2, a); check("R9 compare after reset", a, 0);

    // R1, R4: rate table
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VECS[i].ctrl);
      wr(2'd3, 8'h00);
      rd(2'd3, a);
      repeat (int'(VECS[i].win)) @(negedge clk);
      rd(2'd3, b);
      check($sformatf("R1/R4 rate ctrl=%02h", VECS[i].ctrl),
            int'(8'(b - a)), int'(VECS[i].exp));
    end

    // R3, R10: reserved bit
    wr(2'd0, 8'h13);
    rd(2'd0, a); check("R3 reserved bit reads 0", a, 8'h03);
    wr(2'd1, 8'hA5);
    rd(2'd1, a); check("R10 reload readback", a, 8'hA5);

    // R8, R4: load while stopped
    wr(2'd3, 8'h77);
    rd(2'd3, a); check("R8 load write visible", a, 8'h77);
    repeat (10) @(negedge clk);
    rd(2'd3, a); check("R4 stopped source holds", a, 8'h77);

    // R6, R7: overflow reload and compare
    wr(2'd1, 8'hF0);
    wr(2'd2, 8'hF5);
    rd(2'd2, a); check("R10 compare readback", a, 8'hF5);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'hFD);
    rd(2'd3, a); check("R8 load over running count", a, 8'hFD);
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      check($sformatf("R6 ovf step %0d", i), int'(ovf_pulse), (i == 3) ? 1 : 0);
      check($sformatf("R7 cmp step %0d", i), int'(cmp_pulse), (i == 8) ? 1 : 0);
      if (i == 3) begin
        rd(2'd3, a); check("R6 reload value", a, 8'hF0);
      end
    end

    // R5: external pin
    wr(2'd0, 8'h06);
    wr(2'd3, 8'h00);
    tmr_pin = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd3, a); check("R5 sync latency before", a, 0);
    @(negedge clk);
    rd(2'd3, a); check("R5 rising edge counted", a, 1);
    tmr_pin = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd3, a); check("R5 falling ignored in rising mode", a, 1);
    wr(2'd0, 8'h0E);
    tmr_pin = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd3, a); check("R5 rising ignored in falling mode", a, 1);
    tmr_pin = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd3, a); check("R5 falling edge counted", a, 2);
    wr(2'd0, 8'h02);
    tmr_pin = 1'b1;
    repeat (6) @(negedge clk);
    tmr_pin = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd3, a); check("R5 edge disable", a, 2);

    // R2: select changes keep prescaler count
    wr(2'd0, 8'hE0);
    wr(2'd3, 8'h00);
    rd(2'd3, a);
    for (int i = 0; i < 10; i++) begin
      repeat (40) @(negedge clk);
      wr(2'd0, (i % 2 == 0) ? 8'hC0 : 8'hE0);
    end
    rd(2'd3, b);
    check("R2 prescaler undisturbed", int'(8'(b - a)) >= 3 ? 1 : 0, 1);

    // R9: counter survives reset
    wr(2'd0, 8'h03);
    wr(2'd3, 8'h5A);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd3, a); check("R9 counter held through reset", a, 8'h5A);
    rd(2'd0, a); check("R9 ctrl cleared by reset", a, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule